// File: doc/BRIEF.md
# Rectangle Line Request Generator

This block turns a rectangular crop of a video frame stored in memory into a sequence of line requests. Each request gives the start byte address of one row of the crop and the number of bytes in that row. A start pulse captures the frame base address, the crop position and size, the line stride, a pixel format code, the transfer direction and the line-skip and single-line controls. The block then walks the rows from top to bottom. It offers one request per kept row on a valid/ready stream, and it pulses `done` once the walk is over.

The byte figures come from bit arithmetic. The pixel depth in bits is looked up from the format code. The row length is the depth times the crop width, divided by eight with the remainder dropped. The horizontal offset is worked out the same way from the crop's left edge. Planar 4:2:0 chroma is addressed as if it had 8-bit samples. When it is read from memory, only half as many rows are walked. When the direction is from client to memory, the crop size is clamped to 1920 by 1080. Packing pixels into the row and the memory bus protocol belong to other blocks.

Top module: `rect_line_walker`

## Requirements
- R1: While reset is held, and in the cycle that follows its release, `req_valid` and `done` are both low.
- R2: The depth in bits is set by `pix_fmt`. Codes 0 (luma), 1 (chroma 4:4:4), 2 (chroma 4:2:2) and all unlisted codes give 8. Code 3 (chroma 4:2:0) and code 9 (motion data) give 4. Code 4 (packed YC 4:2:2) and code 6 (16-bit RGB) give 16. Code 5 (YC 4:4:4) and code 7 (24-bit RGB) give 24. Code 8 (32-bit RGB) gives 32.
- R3: Every request of a walk has `req_len` = (depth × width) >> 3.
- R4: The first row's address is `base_addr` + `crop_y` × `line_stride` + ((`crop_x` × depth) >> 3), modulo 2^ADDR_W.
- R5: Row k of the walk has the first row's address plus k × `line_stride`. Rows are offered in increasing k, and each row is offered at most once.
- R6: For code 3 the address math uses a depth of 8. When `to_mem` = 0, the number of rows is floor(`crop_h` / 2).
- R7: When `to_mem` = 1, the width is min(`crop_w`, 1920) and the height is min(`crop_h`, 1080). When `to_mem` = 0, neither is clamped.
- R8: With `skip_even` set, rows whose index k in the walk is even (the first row is k = 0) produce no request. `skip_odd` does the same for odd k. A skipped row still advances the address by one stride.
- R9: With `single_line` set, the walk has exactly one row, whatever `crop_h` is.
- R10: Once `req_valid` is high, it stays high with `req_addr` and `req_len` unchanged until `req_ready` is sampled high.
- R11: `done` is high for exactly one cycle per walk and never at the same time as `req_valid`. If the last row is kept, `done` comes in the cycle right after that row's request is accepted. A walk with no rows raises `done` in the cycle after the start pulse.
- R12: A start pulse that arrives while a walk is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a walk when idle |
| base_addr | input | ADDR_W | Byte address of the frame's first row |
| crop_x | input | DIM_W | Left edge of the crop in pixels |
| crop_y | input | DIM_W | Top edge of the crop in rows |
| crop_w | input | DIM_W | Crop width in pixels |
| crop_h | input | DIM_W | Crop height in rows |
| line_stride | input | STRIDE_W | Bytes between consecutive frame rows |
| pix_fmt | input | 4 | Pixel format code (see R2) |
| to_mem | input | 1 | 1 = client to memory, 0 = memory to client |
| skip_even | input | 1 | Drop rows with even index |
| skip_odd | input | 1 | Drop rows with odd index |
| single_line | input | 1 | Treat the region as a single row |
| req_valid | output | 1 | Line request offered |
| req_ready | input | 1 | Line request accepted |
| req_addr | output | ADDR_W | Start byte address of the row |
| req_len | output | DIM_W+3 | Byte length of the row |
| done | output | 1 | Walk finished (one-cycle pulse) |

## Verification
Most faults show up within a row or two. A wrong depth or a wrong offset register shows in the first request after start. A stride that is misapplied to skipped rows first shows in the request that follows a skipped row. A row counter that is off by one either adds a request after the last expected one or brings `done` too early. The scoreboard catches both when it compares the stream with its queue. A walker that goes back to idle while a request is still stalled breaks the hold rule in the very next cycle.

// File: rtl/rlw_pkg.sv
package rlw_pkg;

   typedef enum logic [3:0] {
      FMT_LUMA   = 4'd0,
      FMT_CHR444 = 4'd1,
      FMT_CHR422 = 4'd2,
      FMT_CHR420 = 4'd3,
      FMT_YC422  = 4'd4,
      FMT_YC444  = 4'd5,
      FMT_RGB16  = 4'd6,
      FMT_RGB24  = 4'd7,
      FMT_RGB32  = 4'd8,
      FMT_MOTION = 4'd9
   } pix_fmt_e;

   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_RUN  = 1'b1
   } walk_state_e;

   // Storage depth in bits for each format code (R2)
   function automatic logic [5:0] fmt_depth(input logic [3:0] code);
      case (code)
         FMT_CHR420, FMT_MOTION: return 6'd4;
         FMT_YC422,  FMT_RGB16:  return 6'd16;
         FMT_YC444,  FMT_RGB24:  return 6'd24;
         FMT_RGB32:              return 6'd32;
         default:                return 6'd8;
      endcase
   endfunction

   // Depth used for addressing: planar 4:2:0 chroma counts as 8 bits (R6)
   function automatic logic [5:0] math_depth(input logic [3:0] code);
      if (code == FMT_CHR420) return 6'd8;
      return fmt_depth(code);
   endfunction

endpackage

// File: rtl/rlw_geom.sv
module rlw_geom
   import rlw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DIM_W     = 12,
   parameter int STRIDE_W  = 16,
   parameter int MAX_OUT_W = 1920,
   parameter int MAX_OUT_H = 1080,
   parameter bit OUT_CLAMP = 1'b1,
   localparam int LEN_W    = DIM_W + 3
) (
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic [DIM_W-1:0]    crop_x,
   input  logic [DIM_W-1:0]    crop_y,
   input  logic [DIM_W-1:0]    crop_w,
   input  logic [DIM_W-1:0]    crop_h,
   input  logic [STRIDE_W-1:0] line_stride,
   input  logic [3:0]          pix_fmt,
   input  logic                to_mem,
   input  logic                single_line,
   output logic [ADDR_W-1:0]   first_addr,
   output logic [LEN_W-1:0]    line_len,
   output logic [DIM_W-1:0]    row_count
);

   localparam int PROD_W = DIM_W + 6;
   localparam int OFF_W  = DIM_W + STRIDE_W;

   logic [5:0]       depth;
   logic [DIM_W-1:0] eff_w;
   logic [DIM_W-1:0] eff_h;
   logic [PROD_W-1:0] w_bits;
   logic [PROD_W-1:0] x_bits;
   logic [OFF_W-1:0]  y_off;

   assign depth = math_depth(pix_fmt);

   // Outbound size limit (R7), selectable at elaboration
   generate
      if (OUT_CLAMP) begin : g_clamp
         assign eff_w = (to_mem && (crop_w > DIM_W'(MAX_OUT_W))) ? DIM_W'(MAX_OUT_W) : crop_w;
         assign eff_h = (to_mem && (crop_h > DIM_W'(MAX_OUT_H))) ? DIM_W'(MAX_OUT_H) : crop_h;
      end else begin : g_no_clamp
         assign eff_w = crop_w;
         assign eff_h = crop_h;
      end
   endgenerate

   assign w_bits   = PROD_W'(eff_w)  * PROD_W'(depth);
   assign x_bits   = PROD_W'(crop_x) * PROD_W'(depth);
   assign y_off    = OFF_W'(crop_y)  * OFF_W'(line_stride);

   assign line_len   = w_bits[PROD_W-1:3];
   assign first_addr = base_addr + ADDR_W'(y_off) + ADDR_W'(x_bits[PROD_W-1:3]);

   always_comb begin
      if (single_line)
         row_count = DIM_W'(1);
      else if (!to_mem && (pix_fmt == FMT_CHR420))
         row_count = eff_h >> 1;
      else
         row_count = eff_h;
   end

endmodule

// File: rtl/rlw_row_seq.sv
module rlw_row_seq
   import rlw_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DIM_W    = 12,
   parameter int STRIDE_W = 16,
   parameter int LEN_W    = DIM_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   first_addr,
   input  logic [LEN_W-1:0]    line_len,
   input  logic [DIM_W-1:0]    row_count,
   input  logic [STRIDE_W-1:0] line_stride,
   input  logic                skip_even,
   input  logic                skip_odd,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [ADDR_W-1:0]   req_addr,
   output logic [LEN_W-1:0]    req_len,
   output logic                done
);

   walk_state_e         state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DIM_W-1:0]    row_q;
   logic [DIM_W-1:0]    rows_q;
   logic [LEN_W-1:0]    len_q;
   logic [STRIDE_W-1:0] stride_q;
   logic                skip_e_q;
   logic                skip_o_q;

   logic running;
   logic at_end;
   logic row_kept;
   logic advance;

   assign running  = (state_q == WS_RUN);
   assign at_end   = (row_q == rows_q);
   assign row_kept = row_q[0] ? !skip_o_q : !skip_e_q;
   assign advance  = running && !at_end && (!row_kept || req_ready);

   assign req_valid = running && !at_end && row_kept;
   assign req_addr  = addr_q;
   assign req_len   = len_q;
   assign done      = running && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WS_IDLE;
         addr_q   <= '0;
         row_q    <= '0;
         rows_q   <= '0;
         len_q    <= '0;
         stride_q <= '0;
         skip_e_q <= 1'b0;
         skip_o_q <= 1'b0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (start) begin
                  state_q  <= WS_RUN;
                  addr_q   <= first_addr;
                  row_q    <= '0;
                  rows_q   <= row_count;
                  len_q    <= line_len;
                  stride_q <= line_stride;
                  skip_e_q <= skip_even;
                  skip_o_q <= skip_odd;
               end
            end
            default: begin
               if (at_end) begin
                  state_q <= WS_IDLE;
               end else if (advance) begin
                  addr_q <= addr_q + ADDR_W'(stride_q);
                  row_q  <= row_q + DIM_W'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/rect_line_walker.sv
module rect_line_walker
   import rlw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DIM_W     = 12,
   parameter int STRIDE_W  = 16,
   parameter int MAX_OUT_W = 1920,
   parameter int MAX_OUT_H = 1080,
   parameter bit OUT_CLAMP = 1'b1,
   localparam int LEN_W    = DIM_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic [DIM_W-1:0]    crop_x,
   input  logic [DIM_W-1:0]    crop_y,
   input  logic [DIM_W-1:0]    crop_w,
   input  logic [DIM_W-1:0]    crop_h,
   input  logic [STRIDE_W-1:0] line_stride,
   input  logic [3:0]          pix_fmt,
   input  logic                to_mem,
   input  logic                skip_even,
   input  logic                skip_odd,
   input  logic                single_line,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [ADDR_W-1:0]   req_addr,
   output logic [LEN_W-1:0]    req_len,
   output logic                done
);

   generate
      if (ADDR_W <= DIM_W + STRIDE_W) begin : g_bad_addr_w
         $error("ADDR_W must exceed DIM_W + STRIDE_W");
      end
      if (OUT_CLAMP && ((MAX_OUT_W >= (1 << DIM_W)) || (MAX_OUT_H >= (1 << DIM_W)))) begin : g_bad_limit
         $error("outbound limits must fit in DIM_W bits");
      end
   endgenerate

   logic [ADDR_W-1:0] g_first;
   logic [LEN_W-1:0]  g_len;
   logic [DIM_W-1:0]  g_rows;

   rlw_geom #(
      .ADDR_W    (ADDR_W),
      .DIM_W     (DIM_W),
      .STRIDE_W  (STRIDE_W),
      .MAX_OUT_W (MAX_OUT_W),
      .MAX_OUT_H (MAX_OUT_H),
      .OUT_CLAMP (OUT_CLAMP)
   ) u_geom (
      .base_addr   (base_addr),
      .crop_x      (crop_x),
      .crop_y      (crop_y),
      .crop_w      (crop_w),
      .crop_h      (crop_h),
      .line_stride (line_stride),
      .pix_fmt     (pix_fmt),
      .to_mem      (to_mem),
      .single_line (single_line),
      .first_addr  (g_first),
      .line_len    (g_len),
      .row_count   (g_rows)
   );

   rlw_row_seq #(
      .ADDR_W   (ADDR_W),
      .DIM_W    (DIM_W),
      .STRIDE_W (STRIDE_W),
      .LEN_W    (LEN_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .first_addr  (g_first),
      .line_len    (g_len),
      .row_count   (g_rows),
      .line_stride (line_stride),
      .skip_even   (skip_even),
      .skip_odd    (skip_odd),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .req_len     (req_len),
      .done        (done)
   );

endmodule

// File: rtl/rlw_checker.sv
module rlw_checker #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [LEN_W-1:0]  req_len,
   input logic              done
);

   AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid); // R10

   AST_STALL_HOLDS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> $stable(req_addr) && $stable(req_len)); // R10

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid); // R11

   AST_LEN_STEADY_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid || $stable(req_len)); // R3

endmodule

bind rect_line_walker rlw_checker #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W)
) u_rlw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_len   (req_len),
   .done      (done)
);

// File: tb/test_rect_line_walker.sv
module test_rect_line_walker;

   localparam int ADDR_W   = 32;
   localparam int DIM_W    = 12;
   localparam int STRIDE_W = 16;
   localparam int LEN_W    = DIM_W + 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [ADDR_W-1:0]   base_addr = '0;
   logic [DIM_W-1:0]    crop_x = '0, crop_y = '0, crop_w = '0, crop_h = '0;
   logic [STRIDE_W-1:0] line_stride = '0;
   logic [3:0]          pix_fmt = '0;
   logic                to_mem = 1'b0, skip_even = 1'b0, skip_odd = 1'b0, single_line = 1'b0;
   logic                req_valid, req_ready, done;
   logic [ADDR_W-1:0]   req_addr;
   logic [LEN_W-1:0]    req_len;

   rect_line_walker i_rect_line_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .crop_x(crop_x), .crop_y(crop_y), .crop_w(crop_w), .crop_h(crop_h),
      .line_stride(line_stride), .pix_fmt(pix_fmt), .to_mem(to_mem),
      .skip_even(skip_even), .skip_odd(skip_odd), .single_line(single_line),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .done(done)
   );

   int    n_checks = 0;
   int    n_errs   = 0;
   int    done_cnt = 0;
   int    cyc      = 0;
   bit    rdy_mode = 1'b0;
   bit    tight_done = 1'b0;
   string cur_tag  = "R5";

   logic [ADDR_W-1:0] exp_addr_q[$];
   logic [LEN_W-1:0]  exp_len_q[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   endtask

   // ready pattern, driven one time unit after the rising edge
   always @(posedge clk) begin
      #1;
      cyc++;
      req_ready = rdy_mode ? ((cyc % 3) != 1) : 1'b1;
   end

   // monitor / scoreboard, samples at the falling edge
   bit                hold_pend = 1'b0;
   bit                prev_acc  = 1'b0;
   logic [ADDR_W-1:0] hold_addr;
   logic [LEN_W-1:0]  hold_len;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            chk(req_valid && req_addr == hold_addr && req_len == hold_len, "R10",
                "stalled request changed", longint'(req_addr), longint'(hold_addr));
         hold_pend = req_valid && !req_ready;
         hold_addr = req_addr;
         hold_len  = req_len;
         if (req_valid && req_ready) begin
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected request addr", longint'(req_addr), 0);
            end else begin
               logic [ADDR_W-1:0] ea;
               logic [LEN_W-1:0]  el;
               ea = exp_addr_q.pop_front();
               el = exp_len_q.pop_front();
               chk(req_addr == ea, cur_tag, "request address", longint'(req_addr), longint'(ea));
               chk(req_len == el, cur_tag, "request length", longint'(req_len), longint'(el));
            end
         end
         if (done) begin
            done_cnt++;
            chk(exp_addr_q.size() == 0, "R11", "done with rows outstanding",
                exp_addr_q.size(), 0);
            if (tight_done)
               chk(prev_acc, "R11", "done not right after last accept", prev_acc, 1);
         end
         prev_acc = req_valid && req_ready;
      end
   end

   function automatic int ref_depth(input int f);
      case (f)
         3, 9:    return 4;
         4, 6:    return 16;
         5, 7:    return 24;
         8:       return 32;
         default: return 8;
      endcase
   endfunction

   // driver: builds the expected stream from the requirements, then starts a walk
   task automatic run_walk(input string tag, input int base, input int x, input int y,
                           input int w, input int h, input int fmt, input bit out,
                           input bit se, input bit so, input bit one, input int stride);
      int d, ew, eh, rows, len, start_dc;
      logic [ADDR_W-1:0] a0;
      bit kept;
      d  = (fmt == 3) ? 8 : ref_depth(fmt);
      ew = (out && w > 1920) ? 1920 : w;
      eh = (out && h > 1080) ? 1080 : h;
      rows = one ? 1 : ((!out && fmt == 3) ? eh / 2 : eh);
      len  = (d * ew) >> 3;
      a0   = ADDR_W'(base) + ADDR_W'(y * stride) + ADDR_W'((x * d) >> 3);
      tight_done = 1'b0;
      for (int r = 0; r < rows; r++) begin
         kept = (r % 2 == 1) ? !so : !se;
         if (kept) begin
            exp_addr_q.push_back(a0 + ADDR_W'(r * stride));
            exp_len_q.push_back(LEN_W'(len));
         end
         tight_done = kept;
      end
      cur_tag = tag;
      start_dc = done_cnt;
      @(posedge clk); #1;
      base_addr = ADDR_W'(base); crop_x = DIM_W'(x); crop_y = DIM_W'(y);
      crop_w = DIM_W'(w); crop_h = DIM_W'(h); pix_fmt = 4'(fmt); to_mem = out;
      skip_even = se; skip_odd = so; single_line = one; line_stride = STRIDE_W'(stride);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      if (rows == 0) begin
         @(negedge clk);
         chk(done == 1'b1, "R11", "empty walk done timing", done, 1);
      end
      wait (done_cnt != start_dc);
      chk(exp_addr_q.size() == 0, tag, "rows left after walk", exp_addr_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      req_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_valid == 1'b0, "R1", "valid in reset", req_valid, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(req_valid == 1'b0 && done == 1'b0, "R1", "quiet after reset", req_valid, 0);

      // first address, luma, steady ready
      run_walk("R4", 'h1000, 10, 2, 64, 4, 0, 0, 0, 0, 0, 256);
      // row stepping with back-pressure
      rdy_mode = 1'b1;
      run_walk("R5", 'h8000, 0, 0, 16, 6, 1, 0, 0, 0, 0, 100);
      // length arithmetic for 24-bit pixels
      run_walk("R3", 'h2000, 3, 1, 5, 3, 7, 0, 0, 0, 0, 64);
      // depth per format code
      run_walk("R2", 'h0, 5, 0, 7, 2, 9, 0, 0, 0, 0, 32);
      run_walk("R2", 'h40, 3, 0, 9, 2, 4, 0, 0, 0, 0, 32);
      run_walk("R2", 'h80, 3, 1, 9, 2, 5, 0, 0, 0, 0, 32);
      run_walk("R2", 'hc0, 3, 0, 9, 2, 6, 0, 0, 0, 0, 32);
      run_walk("R2", 'h100, 3, 2, 9, 2, 8, 0, 0, 0, 0, 48);
      run_walk("R2", 'h140, 3, 0, 9, 2, 2, 0, 0, 0, 0, 32);
      run_walk("R2", 'h180, 3, 0, 9, 2, 13, 0, 0, 0, 0, 32);
      // 4:2:0 chroma, inbound halves rows, outbound does not
      run_walk("R6", 'h4000, 6, 4, 20, 7, 3, 0, 0, 0, 0, 80);
      run_walk("R6", 'h4000, 6, 4, 20, 7, 3, 1, 0, 0, 0, 80);
      // outbound clamp and inbound no clamp
      rdy_mode = 1'b0;
      run_walk("R7", 'h10000, 0, 0, 2000, 1082, 8, 1, 0, 0, 0, 8192);
      run_walk("R7", 'h10000, 0, 0, 2000, 2, 0, 0, 0, 0, 0, 4096);
      // line skipping
      rdy_mode = 1'b1;
      run_walk("R8", 'h500, 1, 1, 8, 5, 0, 0, 1, 0, 0, 16);
      run_walk("R8", 'h500, 1, 1, 8, 5, 0, 0, 0, 1, 0, 16);
      run_walk("R8", 'h500, 1, 1, 8, 5, 0, 0, 1, 1, 0, 16);
      // single line
      run_walk("R9", 'h900, 2, 3, 12, 9, 4, 0, 0, 0, 1, 40);
      // empty region
      run_walk("R11", 'h900, 0, 0, 12, 0, 0, 0, 0, 0, 0, 40);

      // start during a walk is ignored
      fork
         run_walk("R12", 'h3000, 0, 0, 4, 6, 0, 0, 0, 0, 0, 20);
         begin
            repeat (4) @(posedge clk);
            #1;
            start = 1'b1; base_addr = 'h7777; crop_h = DIM_W'(2);
            @(posedge clk); #1;
            start = 1'b0;
         end
      join
      repeat (3) @(negedge clk);
      chk(req_valid == 1'b0, "R12", "extra walk after ignored start", req_valid, 0);

      finish_run();
   end

endmodule